// File: doc/BRIEF.md
# PWM Prescaler Clock Generator

This block is the shared timing source for a bank of PWM channels. It produces a set of tick strobes, each divided down from the master clock. A strobe is a one-cycle enable pulse in the master clock domain and is never used as a derived clock. A free-running binary prescaler supplies eleven taps, at divide ratios from 1 to 1024 in powers of two. Two independent linear dividers each pick one of those taps as their counting source and divide it by a programmable 8-bit factor. The block therefore offers thirteen selectable strobes.

Each channel owns a 4-bit selection code. The code picks which strobe drives that channel's tick output. Codes 0 to 10 select prescaler tap k, which is the master clock divided by 2^k. Code 11 selects linear divider A and code 12 selects linear divider B. Downstream channel counters advance only on cycles where their tick is high.

Top module: `pwm_clkgen`

## Requirements
- R1: While reset is high, and on the first clock after reset is released, every channel tick output is 0.
- R2: With selection code k from 0 to 10, a channel tick is high for exactly one cycle in every 2^k cycles. Code 0 keeps the tick high on every cycle.
- R3: Code 11 routes divider A to the channel and code 12 routes divider B. A divider with tap select t (0 to 10) and factor F (1 to 255) pulses once every F*2^t cycles.
- R4: A divider pulse always arrives exactly one cycle after a pulse of the tap it counts. A channel running that divider therefore ticks one cycle after a channel running the same tap code.
- R5: A divider whose factor is 0 emits no pulses.
- R6: Changing a divider's factor or its tap select clears that divider's count. With tap 0 selected and a new factor F, the first pulse at a channel using that divider appears after the (F+2)th rising edge. The count starts at the first edge that samples the new setting.
- R7: Changing either divider's settings never shifts the phase of the prescaler taps.
- R8: Selection codes 13 to 15 give a channel tick that stays at 0. A divider with a tap select from 11 to 15 emits no pulses.
- R9: Each channel follows its own selection code, independently of the codes held by the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| diva_fac_i | input | FAC_W | Divide factor of divider A (0 turns it off) |
| diva_tap_i | input | SEL_W | Prescaler tap counted by divider A |
| divb_fac_i | input | FAC_W | Divide factor of divider B (0 turns it off) |
| divb_tap_i | input | SEL_W | Prescaler tap counted by divider B |
| ch_code_i | input | NCH*SEL_W | Per-channel selection codes; channel n uses bits n*SEL_W upward |
| ch_tick_o | output | NCH | Per-channel one-cycle tick strobes |

## Verification
Several rules are checked by the assertions on every cycle:
- The prescaler taps are nested, so a pulse on a slow tap always coincides with pulses on every faster tap.
- A divider pulse always follows a pulse of its source tap.
- A divider is silent when its factor is 0, when its tap select is out of range, and in the cycle after a setting change.
- An invalid channel code gives no tick.

Other behaviour can only be shown by the bench scenarios. These cover the exact pulse intervals for each tap and each divider setting, and the precise latency from a divider restart to its first pulse. They also cover the phase of the prescaler staying fixed across divider rewrites, and the independence between channels.

// File: rtl/pwm_clkgen_pkg.sv
package pwm_clkgen_pkg;
  localparam int NTAPS  = 11;          // binary prescaler taps: div 1 .. div 1024
  localparam int FAC_W  = 8;           // linear divider factor width
  localparam int SEL_W  = 4;           // selection code width
  localparam int NSRC   = NTAPS + 2;   // taps plus two linear dividers
  localparam int CODE_A = NTAPS;       // code of divider A
  localparam int CODE_B = NTAPS + 1;   // code of divider B
endpackage

// File: rtl/pwm_clkgen_prescale.sv
module pwm_clkgen_prescale #(
  parameter int NTAPS = pwm_clkgen_pkg::NTAPS
) (
  input  logic             clk,
  input  logic             rst,
  output logic [NTAPS-1:0] tap_o
);
  localparam int CW = (NTAPS > 1) ? NTAPS - 1 : 1;

  logic [CW-1:0]    cnt;
  logic [NTAPS-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  // tap k fires when the low k counter bits are all ones
  assign hit[0] = 1'b1;
  for (genvar k = 1; k < NTAPS; k++) begin : g_hit
    assign hit[k] = &cnt[k-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) tap_o <= '0;
    else     tap_o <= hit;
  end

  // R2: taps are nested, so a slower tap implies every faster one
  for (genvar k = 1; k < NTAPS; k++) begin : g_nest
    a_r2_nested: assert property (@(posedge clk) disable iff (rst)
      tap_o[k] |-> tap_o[k-1]);
  end
endmodule

// File: rtl/pwm_clkgen_lindiv.sv
module pwm_clkgen_lindiv #(
  parameter int NTAPS = pwm_clkgen_pkg::NTAPS,
  parameter int FAC_W = pwm_clkgen_pkg::FAC_W,
  parameter int SEL_W = pwm_clkgen_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NTAPS-1:0] tap_i,
  input  logic [SEL_W-1:0] tap_sel_i,
  input  logic [FAC_W-1:0] fac_i,
  output logic             tick_o
);
  logic [FAC_W-1:0] cnt;
  logic [FAC_W-1:0] fac_q;
  logic [SEL_W-1:0] sel_q;
  logic             changed;
  logic             src;

  assign changed = (fac_i != fac_q) || (tap_sel_i != sel_q);

  always_comb begin
    src = 1'b0;
    for (int k = 0; k < NTAPS; k++)
      if (sel_q == SEL_W'(k)) src = tap_i[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      fac_q  <= '0;
      sel_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      fac_q  <= fac_i;
      sel_q  <= tap_sel_i;
      if (changed) begin
        cnt <= '0;
      end else if (fac_q != '0 && src) begin
        if (cnt == fac_q - 1'b1) begin
          cnt    <= '0;
          tick_o <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R4: every divider pulse follows a pulse of the counted tap
  a_r4_on_tap: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(src));
  // R5: a zero factor keeps the divider silent
  a_r5_off: assert property (@(posedge clk) disable iff (rst)
    (fac_i == '0) |=> !tick_o);
  // R6: a setting change restarts the count without a pulse
  a_r6_restart: assert property (@(posedge clk) disable iff (rst)
    changed |=> !tick_o);
  // R8: an out-of-range tap select keeps the divider silent
  a_r8_bad_tap: assert property (@(posedge clk) disable iff (rst)
    (tap_sel_i >= SEL_W'(NTAPS)) |=> !tick_o);
endmodule

// File: rtl/pwm_clkgen_chsel.sv
module pwm_clkgen_chsel #(
  parameter int NSRC  = pwm_clkgen_pkg::NSRC,
  parameter int SEL_W = pwm_clkgen_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_i,
  input  logic [SEL_W-1:0] code_i,
  output logic             tick_o
);
  logic pick;

  always_comb begin
    pick = 1'b0;
    for (int k = 0; k < NSRC; k++)
      if (code_i == SEL_W'(k)) pick = src_i[k];
  end

  always_ff @(posedge clk) begin
    if (rst) tick_o <= 1'b0;
    else     tick_o <= pick;
  end

  // R8: codes beyond the last source give no tick
  a_r8_bad_code: assert property (@(posedge clk) disable iff (rst)
    (code_i >= SEL_W'(NSRC)) |=> !tick_o);
  // R9: a tick needs some source strobe on the previous cycle
  a_r9_from_source: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(src_i != '0));
endmodule

// File: rtl/pwm_clkgen.sv
module pwm_clkgen #(
  parameter int NCH   = 4,
  parameter int NTAPS = pwm_clkgen_pkg::NTAPS,
  parameter int FAC_W = pwm_clkgen_pkg::FAC_W,
  parameter int SEL_W = pwm_clkgen_pkg::SEL_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [FAC_W-1:0]     diva_fac_i,
  input  logic [SEL_W-1:0]     diva_tap_i,
  input  logic [FAC_W-1:0]     divb_fac_i,
  input  logic [SEL_W-1:0]     divb_tap_i,
  input  logic [NCH*SEL_W-1:0] ch_code_i,
  output logic [NCH-1:0]       ch_tick_o
);
  localparam int NSRC = NTAPS + 2;

  logic [NTAPS-1:0] taps;
  logic             div_a;
  logic             div_b;
  logic [NSRC-1:0]  srcs;

  pwm_clkgen_prescale #(.NTAPS(NTAPS)) u_pre (
    .clk(clk), .rst(rst), .tap_o(taps)
  );

  pwm_clkgen_lindiv #(.NTAPS(NTAPS), .FAC_W(FAC_W), .SEL_W(SEL_W)) u_div_a (
    .clk(clk), .rst(rst), .tap_i(taps), .tap_sel_i(diva_tap_i),
    .fac_i(diva_fac_i), .tick_o(div_a)
  );

  pwm_clkgen_lindiv #(.NTAPS(NTAPS), .FAC_W(FAC_W), .SEL_W(SEL_W)) u_div_b (
    .clk(clk), .rst(rst), .tap_i(taps), .tap_sel_i(divb_tap_i),
    .fac_i(divb_fac_i), .tick_o(div_b)
  );

  // source order fixes the codes: taps, then divider A, then divider B
  assign srcs = {div_b, div_a, taps};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_clkgen_chsel #(.NSRC(NSRC), .SEL_W(SEL_W)) u_sel (
      .clk(clk), .rst(rst), .src_i(srcs),
      .code_i(ch_code_i[c*SEL_W +: SEL_W]), .tick_o(ch_tick_o[c])
    );
  end

  // R1: no tick on the first cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (ch_tick_o == '0));
endmodule

// File: tb/pwm_clkgen_test.sv
module pwm_clkgen_test;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [7:0]     diva_fac = '0;
  logic [3:0]     diva_tap = '0;
  logic [7:0]     divb_fac = '0;
  logic [3:0]     divb_tap = '0;
  logic [NCH*4-1:0] ch_code = '0;
  logic [NCH-1:0] ch_tick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pending = 0;
  int     ch_q[$];
  int     exp_q[$];
  string  tag_q[$];

  pwm_clkgen #(.NCH(NCH)) uut (
    .clk(clk), .rst(rst),
    .diva_fac_i(diva_fac), .diva_tap_i(diva_tap),
    .divb_fac_i(divb_fac), .divb_tap_i(divb_tap),
    .ch_code_i(ch_code), .ch_tick_o(ch_tick)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_code(input int ch, input int code);
    ch_code[ch*4 +: 4] = 4'(code);
  endtask

  // driver: queue one expected interval and wait for the monitor
  task automatic expect_iv(input int ch, input int iv, input string tag);
    ch_q.push_back(ch);
    exp_q.push_back(iv);
    tag_q.push_back(tag);
    pending++;
    wait (pending == 0);
  endtask

  task automatic count_ticks(input int ch, input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ch_tick[ch]) cnt++;
    end
  endtask

  // monitor: skip one interval after a reconfiguration, compare the next
  initial begin
    int ch, iv, n;
    forever begin
      wait (pending > 0);
      ch = ch_q[0];
      do @(negedge clk); while (!ch_tick[ch]);
      for (int pass = 0; pass < 2; pass++) begin
        n = 0;
        do begin @(negedge clk); n++; end while (!ch_tick[ch]);
      end
      iv = exp_q[0];
      check(n == iv, tag_q[0], n, iv);
      void'(ch_q.pop_front());
      void'(exp_q.pop_front());
      tag_q.pop_front();
      pending--;
    end
  end

  initial begin
    int cnt, n, t0, t1;
    bit prev, ok;

    // R1: quiet during reset and on the first cycle after it
    repeat (4) @(negedge clk);
    check(ch_tick == '0, "R1 during reset", int'(ch_tick), 0);
    set_code(0, 0);
    rst = 1'b0;
    @(negedge clk);
    check(ch_tick == '0, "R1 first cycle", int'(ch_tick), 0);

    // R2 and R9: four channels on four different taps at once
    set_code(0, 0); set_code(1, 1); set_code(2, 4); set_code(3, 10);
    expect_iv(0, 1, "R2 R9 code0");
    expect_iv(1, 2, "R2 R9 code1");
    expect_iv(2, 16, "R2 R9 code4");
    expect_iv(3, 1024, "R2 R9 code10");

    // R3: dividers on various taps and factors
    diva_tap = 4'd3; diva_fac = 8'd5;
    divb_tap = 4'd2; divb_fac = 8'd255;
    set_code(0, 11); set_code(1, 12);
    expect_iv(0, 40, "R3 divA tap3 f5");
    expect_iv(1, 1020, "R3 divB tap2 f255");
    diva_tap = 4'd0; diva_fac = 8'd1;
    divb_tap = 4'd1; divb_fac = 8'd3;
    expect_iv(0, 1, "R3 divA tap0 f1");
    expect_iv(1, 6, "R3 divB tap1 f3");

    // R4: divider on tap 3 ticks one cycle after the tap 3 channel
    diva_tap = 4'd3; diva_fac = 8'd5;
    set_code(0, 11); set_code(1, 3);
    repeat (100) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      prev = 1'b0;
      do begin prev = ch_tick[1]; @(negedge clk); end while (!ch_tick[0]);
      check(prev == 1'b1, "R4 follows tap", int'(prev), 1);
    end

    // R5: factor zero silences divider A
    diva_fac = 8'd0;
    repeat (4) @(negedge clk);
    count_ticks(0, 500, cnt);
    check(cnt == 0, "R5 factor zero", cnt, 0);

    // R8: invalid channel codes and an out-of-range divider tap
    set_code(1, 13); set_code(2, 15);
    diva_tap = 4'd12; diva_fac = 8'd2;
    set_code(0, 11);
    repeat (4) @(negedge clk);
    count_ticks(1, 200, cnt);
    check(cnt == 0, "R8 code13", cnt, 0);
    count_ticks(2, 200, cnt);
    check(cnt == 0, "R8 code15", cnt, 0);
    count_ticks(0, 200, cnt);
    check(cnt == 0, "R8 divider tap12", cnt, 0);

    // R6: restart latency after a factor change on tap 0
    diva_tap = 4'd0; diva_fac = 8'd200;
    repeat (50) @(negedge clk);
    diva_fac = 8'd7;
    n = 0;
    do begin @(negedge clk); n++; end while (!ch_tick[0] && n < 400);
    check(n == 9, "R6 restart latency", n, 9);
    expect_iv(0, 7, "R6 interval after restart");

    // R7: prescaler phase unchanged by divider rewrites
    set_code(3, 10);
    do @(negedge clk); while (!ch_tick[3]);
    t0 = cyc;
    repeat (300) @(negedge clk);
    diva_fac = 8'd33; diva_tap = 4'd5;
    repeat (100) @(negedge clk);
    divb_fac = 8'd0; divb_tap = 4'd9;
    do @(negedge clk); while (!ch_tick[3]);
    t1 = cyc;
    ok = (t1 - t0) == 1024;
    check(ok, "R7 prescaler phase", t1 - t0, 1024);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule